// File: doc/BRIEF.md
# Always-On Millisecond Time Counter with Coherent Seconds Capture

This block keeps wall time in an always-on domain that is clocked from a 32,768 Hz source. It holds two counts: milliseconds within the current second, and elapsed seconds. A fractional accumulator converts input ticks into millisecond ticks. On each input tick it adds `MS_STEP` and subtracts `TICK_HZ` whenever the sum reaches that limit. Over one second of input ticks, this yields exactly `MS_PER_S` millisecond ticks, and no drift builds up.

Software reads a torn-free timestamp with two accesses. It reads the millisecond register first. That read also latches the seconds count into a separate shadow register. It then reads the shadow register. Software combines the two values as seconds × 1000 + milliseconds. The shadow is one shared latch. If two readers interleave their accesses, one of them can corrupt the other's timestamp, so the accesses must be serialised in software.

The register port is synchronous to the counter clock. It accepts one access in every cycle in which `bus_sel` is high, and it never stalls. Read data appears one cycle after the request, qualified by `bus_rvalid`.

Top module: `lp_time_counter`

## Requirements
- R1: After reset, the seconds count, the millisecond count, the accumulator and the shadow register are all zero, and `bus_rvalid` is low.
- R2: After n input ticks since reset or since the last seconds load, the total number of elapsed milliseconds is floor(n × MS_STEP / TICK_HZ). The seconds count is the load value plus total / MS_PER_S, and the millisecond count is total mod MS_PER_S.
- R3: The millisecond count never exceeds MS_PER_S−1. When it wraps from MS_PER_S−1 to 0, the seconds count increments in that same clock cycle.
- R4: A write to offset 0x08 loads the seconds count from `bus_wdata`, and it clears both the millisecond count and the accumulator. When an input tick arrives in the same cycle, the write takes precedence.
- R5: A read of offset 0x10 returns the millisecond count and copies the seconds count into the shadow register. A read of offset 0x0C returns the shadow. The shadow changes on no other event.
- R6: A read returns the state after the update of the cycle in which it is issued. When a millisecond read coincides with a seconds increment, the read returns 0 and the shadow captures the incremented seconds value.
- R7: Offsets 0x0C and 0x10 are read-only. Writes to them leave every count and the shadow unchanged.
- R8: Reads of any offset other than 0x08, 0x0C and 0x10 return zero. Writes to such offsets change nothing.
- R9: `bus_rvalid` is high in exactly the cycle after a read request. Writes do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32,768 Hz input tick |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data qualifier, one cycle after a read |

## Verification
The bench builds the block with its default parameters: TICK_HZ = 32768, MS_STEP = 1000 and MS_PER_S = 1000. With these values the accumulator runs over its real fractional pattern. The bench holds `tick_en` high for long runs, so that a full second takes 32,768 cycles. This brings the 999-to-0 wrap and the concurrent shadow capture within reach. It also lets the bench check that a load discards a partly filled accumulator, using a tick count chosen so that a leftover remainder would change the result.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register offsets; software depends on these positions.
  localparam logic [7:0] OFS_SEC    = 8'h08;
  localparam logic [7:0] OFS_SHADOW = 8'h0C;
  localparam logic [7:0] OFS_MS     = 8'h10;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_SEC,
    RS_SHADOW,
    RS_MS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_SEC:    return RS_SEC;
      OFS_SHADOW: return RS_SHADOW;
      OFS_MS:     return RS_MS;
      default:    return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ms_prescaler.sv
module rtc_ms_prescaler #(
  parameter int TICK_HZ = 32768,
  parameter int MS_STEP = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick_en,
  output logic ms_tick
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_STEP);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(MS_STEP);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  always_comb begin
    acc_sum = acc_q + STEP;
    ms_tick = tick_en && !clear && (acc_sum >= LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (tick_en) begin
      acc_q <= (acc_sum >= LIMIT) ? (acc_sum - LIMIT) : acc_sum;
    end
  end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  localparam int MS_W    = $clog2(MS_PER_S)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [MS_W-1:0]  ms_q,
  output logic [SEC_W-1:0] sec_q,
  output logic [MS_W-1:0]  ms_nxt,
  output logic [SEC_W-1:0] sec_nxt
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  logic wrap;

  always_comb begin
    wrap    = ms_tick && (ms_q == MS_LAST);
    ms_nxt  = ms_q;
    sec_nxt = sec_q;
    if (load) begin
      ms_nxt  = '0;
      sec_nxt = load_val;
    end else if (ms_tick) begin
      ms_nxt = wrap ? '0 : ms_q + 1'b1;
      if (wrap) sec_nxt = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_nxt;
      sec_q <= sec_nxt;
    end
  end
endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [MS_W-1:0]   ms_nxt,
  input  logic [SEC_W-1:0]  sec_nxt,
  output logic              sec_load,
  output logic [SEC_W-1:0]  sec_load_val,
  output logic [SEC_W-1:0]  shadow_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  reg_sel_e    sel;
  logic        rd_req;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    sel          = decode_ofs(8'(bus_addr));
    rd_req       = bus_sel && !bus_wr;
    sec_load     = bus_sel && bus_wr && (sel == RS_SEC);
    sec_load_val = SEC_W'(bus_wdata);
    case (sel)
      RS_SEC:    rd_mux = DATA_W'(sec_nxt);
      RS_SHADOW: rd_mux = DATA_W'(shadow_q);
      RS_MS:     rd_mux = DATA_W'(ms_nxt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
      if (rd_req && sel == RS_MS) shadow_q <= sec_nxt;
    end
  end
endmodule

// File: rtl/lp_time_counter.sv
module lp_time_counter #(
  parameter int TICK_HZ  = 32768,
  parameter int MS_STEP  = 1000,
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int MS_W = $clog2(MS_PER_S);

  logic             ms_tick;
  logic             sec_load;
  logic [SEC_W-1:0] sec_load_val;
  logic [MS_W-1:0]  ms_q, ms_nxt;
  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [SEC_W-1:0] shadow_q;

  rtc_ms_prescaler #(.TICK_HZ(TICK_HZ), .MS_STEP(MS_STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(sec_load), .tick_en(tick_en), .ms_tick(ms_tick)
  );

  rtc_time_count #(.MS_PER_S(MS_PER_S), .SEC_W(SEC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .load(sec_load),
    .load_val(sec_load_val), .ms_q(ms_q), .sec_q(sec_q),
    .ms_nxt(ms_nxt), .sec_nxt(sec_nxt)
  );

  rtc_reg_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ms_nxt(ms_nxt), .sec_nxt(sec_nxt),
    .sec_load(sec_load), .sec_load_val(sec_load_val), .shadow_q(shadow_q),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );
endmodule

// File: rtl/lp_time_counter_chk.sv
module lp_time_counter_chk #(
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  localparam int MS_W    = $clog2(MS_PER_S)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              ms_tick,
  input logic [MS_W-1:0]   ms_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  shadow_q
);
  logic rd_req, rd_ms, wr_sec, unmapped;
  assign rd_req   = bus_sel && !bus_wr;
  assign rd_ms    = rd_req && (8'(bus_addr) == 8'h10);
  assign wr_sec   = bus_sel && bus_wr && (8'(bus_addr) == 8'h08);
  assign unmapped = (8'(bus_addr) != 8'h08) && (8'(bus_addr) != 8'h0C) && (8'(bus_addr) != 8'h10);

  assert_ms_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ms_q) < MS_PER_S);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && 32'(ms_q) == MS_PER_S - 1 && !wr_sec) |=> (sec_q == $past(sec_q) + 1'b1) && (ms_q == '0));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec_q == $past(SEC_W'(bus_wdata))) && (ms_q == '0));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ms |=> (shadow_q == sec_q) && (bus_rdata == DATA_W'(ms_q)));

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ms |=> $stable(shadow_q));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && unmapped) |=> bus_rdata == '0);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_no_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind lp_time_counter lp_time_counter_chk #(
  .MS_PER_S(MS_PER_S), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .ms_tick(ms_tick), .ms_q(ms_q), .sec_q(sec_q),
  .shadow_q(shadow_q)
);

// File: tb/sim_lp_time_counter.sv
module sim_lp_time_counter;
  localparam longint HZ = 32768;
  localparam longint STEP = 1000;
  localparam longint MSPS = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int fails = 0;
  longint n_ticks = 0;
  longint sec_base = 0;
  logic [31:0] rd;

  lp_time_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ms();
    return 32'(((n_ticks * STEP) / HZ) % MSPS);
  endfunction

  function automatic logic [31:0] exp_sec();
    return 32'(sec_base + ((n_ticks * STEP) / HZ) / MSPS);
  endfunction

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R9", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R9", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    n_ticks += n;
  endtask

  task automatic t_reset();
    check("R1", 32'(bus_rvalid), 32'd0);
    bus_read(8'h0C, rd); check("R1", rd, 32'd0);
    bus_read(8'h08, rd); check("R1", rd, 32'd0);
    bus_read(8'h10, rd); check("R1", rd, 32'd0);
  endtask

  task automatic t_count();
    run_ticks(1000);
    bus_read(8'h10, rd); check("R2", rd, exp_ms());
    run_ticks(33);
    bus_read(8'h10, rd); check("R2", rd, exp_ms());
    bus_read(8'h0C, rd); check("R5", rd, exp_sec());
  endtask

  task automatic t_load();
    bus_write(8'h08, 32'd5);
    n_ticks = 0; sec_base = 5;
    bus_read(8'h10, rd); check("R4", rd, 32'd0);
    run_ticks(16);   // a kept remainder would already yield one millisecond
    bus_read(8'h10, rd); check("R4", rd, exp_ms());
    bus_read(8'h08, rd); check("R4", rd, 32'd5);
  endtask

  task automatic t_wrap();
    run_ticks(32767 - 16);
    bus_read(8'h10, rd); check("R3", rd, 32'd999);
    // tick and millisecond read in the same cycle: the wrap cycle
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; n_ticks += 1;
    check("R6", bus_rdata, 32'd0);
    bus_read(8'h0C, rd); check("R6", rd, 32'd6);
    bus_read(8'h08, rd); check("R3", rd, exp_sec());
  endtask

  task automatic t_shadow_hold();
    run_ticks(32768);
    bus_read(8'h0C, rd); check("R5", rd, 32'd6);
    bus_read(8'h08, rd); check("R5", rd, 32'd7);
    bus_read(8'h10, rd); check("R5", rd, exp_ms());
    bus_read(8'h0C, rd); check("R5", rd, 32'd7);
  endtask

  task automatic t_readonly();
    bus_write(8'h0C, 32'hDEAD_BEEF);
    bus_read(8'h0C, rd); check("R7", rd, 32'd7);
    bus_write(8'h10, 32'd123);
    bus_read(8'h10, rd); check("R7", rd, exp_ms());
    bus_read(8'h08, rd); check("R7", rd, exp_sec());
  endtask

  task automatic t_unmapped();
    bus_read(8'h00, rd); check("R8", rd, 32'd0);
    bus_read(8'h04, rd); check("R8", rd, 32'd0);
    bus_read(8'h14, rd); check("R8", rd, 32'd0);
    bus_write(8'h04, 32'd99);
    bus_write(8'h0E, 32'd42);
    bus_read(8'h08, rd); check("R8", rd, exp_sec());
    bus_read(8'h10, rd); check("R8", rd, exp_ms());
  endtask

  task automatic t_load_vs_tick();
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd40;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    n_ticks = 0; sec_base = 40;
    bus_read(8'h08, rd); check("R4", rd, 32'd40);
    bus_read(8'h10, rd); check("R4", rd, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_load();
    t_wrap();
    t_shadow_hold();
    t_readonly();
    t_unmapped();
    t_load_vs_tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule